// File: doc/BRIEF.md
# Multi-Size LRU Stack Tag Store

This block is a small fully associative tag store with a single set. It keeps every entry in a strict recency order, from most recent (position 0) to least recent (position N-1). Each entry holds a per-entry position counter. The address is split into a block offset, which is discarded, and a tag, which is everything above the offset. An access looks the tag up in all entries at once, reports the hit and the entry index, and promotes the entry to the front of the order.

Because a stack of recency positions also describes every smaller LRU store, each access also returns a residency mask. The mask has one bit for each power-of-two store size below the full size, and it shows which of those smaller stores would have hit. Hit and miss counters are kept for every one of those sizes and for the full store, along with a total access counter. A single access stream therefore yields miss curves for several capacities at once.

A side-effect-free probe port, a victim/insert port and an invalidate port complete the block. Only one operation acts in each cycle. The access, probe, mask and victim outputs are combinational from the inputs and the current state. Updates take effect at the next rising clock edge. After an external reset is released, the internal reset stays asserted for two more clock edges before operations take effect.

Top module: `mslru_tag_store`

## Requirements
- R1: The tag is acc_addr/prb_addr/ins_addr bits [ADDR_W-1:OFF_W]. The low OFF_W offset bits never affect a match.
- R2: acc_hit is 1 when a valid entry holds the access tag, and acc_idx then gives the lowest such entry index. On a miss, acc_hit is 0 and acc_mask is all zero.
- R3: An acted access that hits moves the entry to position 0. Every entry whose position was below the old position moves back by one, and all other positions keep their value.
- R4: acc_mask has SIZES = log2(N) bits. Bit k is 1 exactly when the access hits at a position below 2^k, so with N=16 the bits stand for stores of 1, 2, 4 and 8 entries.
- R5: The probe port reports prb_hit/prb_idx with the same matching rule. Probes never change recency, validity or counters.
- R6: vic_idx is the lowest-index invalid entry when one exists. Otherwise it is the entry at position N-1.
- R7: An acted insert writes the tag into entry vic_idx, sets it valid and promotes it to position 0 by the rule of R3.
- R8: An acted invalidate clears the valid state of entry inv_idx, so that entry no longer matches. Positions are left unchanged.
- R9: Each acted access adds one to acc_cnt. For k < SIZES, it adds one to hit_cnt[k] when acc_mask[k] is 1, and to miss_cnt[k] otherwise. Index SIZES counts the full store by acc_hit. All counters wrap.
- R10: At most one operation acts per cycle, with priority access over insert over invalidate. A request of lower priority in the same cycle is ignored.
- R11: After reset all entries are invalid, entry i sits at position i and all counters are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_valid | input | 1 | Access request |
| acc_addr | input | ADDR_W | Access address |
| acc_hit | output | 1 | Access tag found in a valid entry |
| acc_idx | output | IDX_W | Entry index of the access hit |
| acc_mask | output | SIZES | Per-size residency mask of the access |
| prb_addr | input | ADDR_W | Probe address |
| prb_hit | output | 1 | Probe tag found |
| prb_idx | output | IDX_W | Entry index of the probe hit |
| ins_valid | input | 1 | Insert request |
| ins_addr | input | ADDR_W | Address to insert |
| vic_idx | output | IDX_W | Entry the next insert will fill |
| inv_valid | input | 1 | Invalidate request |
| inv_idx | input | IDX_W | Entry to invalidate |
| hit_cnt | output | (SIZES+1)*CNT_W | Hit counters, index k for size 2^k, index SIZES for the full store |
| miss_cnt | output | (SIZES+1)*CNT_W | Miss counters, same indexing |
| acc_cnt | output | CNT_W | Total acted accesses |

## Verification
Several properties are checked on every cycle. The mask must be a thermometer code and must be zero on a miss. A hitting access must leave its entry at position 0, and exactly one entry may ever sit at position 0. Cycles without an access or insert must leave the order untouched. An invalidated entry must read invalid afterwards, and the access counter must advance on each access. The bench's scenarios are what show that the order evolves correctly over long sequences and that the mask reflects it. They also cover the choice of victim between free and least-recent entries, the offset being ignored, and the per-size hit and miss totals. The resolution of colliding requests is also shown only by the scenarios.

// File: rtl/mslru_pkg.sv
package mslru_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_ACC  = 2'd1,
    OP_INS  = 2'd2,
    OP_INV  = 2'd3
  } op_e;
endpackage

// File: rtl/mslru_match.sv
// Parallel tag compare across all entries; lowest matching index wins.
module mslru_match #(
  parameter int N     = 16,
  parameter int TAG_W = 28,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0][TAG_W-1:0] tags,
  input  logic [N-1:0]            vld,
  input  logic [TAG_W-1:0]        key,
  output logic                    hit,
  output logic [IDX_W-1:0]        idx
);
  logic [N-1:0] eq;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign eq[i] = vld[i] && (tags[i] == key);
  end

  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (eq[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/mslru_order.sv
// Per-entry recency position counters forming a permutation of 0..N-1.
module mslru_order #(
  parameter int N = 16,
  localparam int IDX_W = $clog2(N)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    upd_en,
  input  logic [IDX_W-1:0]        upd_idx,
  output logic [N-1:0][IDX_W-1:0] pos,
  output logic [IDX_W-1:0]        lru_idx
);
  logic [N-1:0][IDX_W-1:0] pos_d;
  logic [IDX_W-1:0]        old_pos;

  assign old_pos = pos[upd_idx];

  always_comb begin
    pos_d = pos;
    if (upd_en) begin
      for (int i = 0; i < N; i++) begin
        if (IDX_W'(i) == upd_idx) begin
          pos_d[i] = '0;
        end else if (pos[i] < old_pos) begin
          pos_d[i] = pos[i] + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) pos[i] <= IDX_W'(i);
    end else if (upd_en) begin
      pos <= pos_d;
    end
  end

  always_comb begin
    lru_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (pos[i] == IDX_W'(N - 1)) lru_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/mslru_stats.sv
// Hit/miss counters per tracked size plus the full store, and a total.
module mslru_stats #(
  parameter int SIZES = 4,
  parameter int CNT_W = 16
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        en,
  input  logic                        hit,
  input  logic [SIZES-1:0]            mask,
  output logic [SIZES:0][CNT_W-1:0]   hit_cnt,
  output logic [SIZES:0][CNT_W-1:0]   miss_cnt,
  output logic [CNT_W-1:0]            acc_cnt
);
  logic [SIZES:0] res;
  assign res = {hit, mask};

  for (genvar k = 0; k <= SIZES; k++) begin : g_size
    logic [CNT_W-1:0] hit_d, miss_d;

    always_comb begin
      hit_d  = hit_cnt[k];
      miss_d = miss_cnt[k];
      if (en) begin
        if (res[k]) hit_d  = hit_cnt[k] + 1'b1;
        else        miss_d = miss_cnt[k] + 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hit_cnt[k]  <= '0;
        miss_cnt[k] <= '0;
      end else if (en) begin
        hit_cnt[k]  <= hit_d;
        miss_cnt[k] <= miss_d;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  acc_cnt <= '0;
    else if (en) acc_cnt <= acc_cnt + 1'b1;
  end
endmodule

// File: rtl/mslru_tag_store.sv
module mslru_tag_store
  import mslru_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 4,
  parameter int N      = 16,
  parameter int CNT_W  = 16,
  localparam int IDX_W = $clog2(N),
  localparam int SIZES = IDX_W,
  localparam int TAG_W = ADDR_W - OFF_W
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      acc_valid,
  input  logic [ADDR_W-1:0]         acc_addr,
  output logic                      acc_hit,
  output logic [IDX_W-1:0]          acc_idx,
  output logic [SIZES-1:0]          acc_mask,
  input  logic [ADDR_W-1:0]         prb_addr,
  output logic                      prb_hit,
  output logic [IDX_W-1:0]          prb_idx,
  input  logic                      ins_valid,
  input  logic [ADDR_W-1:0]         ins_addr,
  output logic [IDX_W-1:0]          vic_idx,
  input  logic                      inv_valid,
  input  logic [IDX_W-1:0]          inv_idx,
  output logic [SIZES:0][CNT_W-1:0] hit_cnt,
  output logic [SIZES:0][CNT_W-1:0] miss_cnt,
  output logic [CNT_W-1:0]          acc_cnt
);
  // Reset: asserted asynchronously, released after two clock edges.
  logic rst_meta_n, rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_q_n, rst_meta_n} <= 2'b00;
    else        {rst_q_n, rst_meta_n} <= {rst_meta_n, 1'b1};
  end

  // One operation per cycle, access first.
  op_e op;
  always_comb begin
    if (acc_valid)      op = OP_ACC;
    else if (ins_valid) op = OP_INS;
    else if (inv_valid) op = OP_INV;
    else                op = OP_NONE;
  end

  logic [N-1:0][TAG_W-1:0] tag_q;
  logic [N-1:0]            vld_q, vld_d;
  logic [N-1:0][IDX_W-1:0] pos;
  logic [IDX_W-1:0]        lru_idx, free_idx, hit_pos, upd_idx;
  logic                    any_free, upd_en;

  mslru_match #(.N(N), .TAG_W(TAG_W)) u_acc_match (
    .tags(tag_q), .vld(vld_q), .key(acc_addr[ADDR_W-1:OFF_W]),
    .hit(acc_hit), .idx(acc_idx)
  );

  mslru_match #(.N(N), .TAG_W(TAG_W)) u_prb_match (
    .tags(tag_q), .vld(vld_q), .key(prb_addr[ADDR_W-1:OFF_W]),
    .hit(prb_hit), .idx(prb_idx)
  );

  // Victim: lowest free entry first, else the least recent one.
  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!vld_q[i]) begin
        any_free = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end
  assign vic_idx = any_free ? free_idx : lru_idx;

  assign upd_en  = ((op == OP_ACC) && acc_hit) || (op == OP_INS);
  assign upd_idx = (op == OP_INS) ? vic_idx : acc_idx;

  mslru_order #(.N(N)) u_order (
    .clk(clk), .rst_n(rst_q_n), .upd_en(upd_en), .upd_idx(upd_idx),
    .pos(pos), .lru_idx(lru_idx)
  );

  // Residency mask: size 2^k holds positions below 2^k.
  assign hit_pos = pos[acc_idx];
  for (genvar k = 0; k < SIZES; k++) begin : g_mask
    assign acc_mask[k] = acc_hit && ({1'b0, hit_pos} < (IDX_W + 1)'(1 << k));
  end

  // Valid bits.
  always_comb begin
    vld_d = vld_q;
    case (op)
      OP_INS:  vld_d[vic_idx] = 1'b1;
      OP_INV:  vld_d[inv_idx] = 1'b0;
      default: vld_d = vld_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) vld_q <= '0;
    else if ((op == OP_INS) || (op == OP_INV)) vld_q <= vld_d;
  end

  // Tag storage: no reset, written only on insert.
  always_ff @(posedge clk) begin
    if (rst_q_n && (op == OP_INS)) tag_q[vic_idx] <= ins_addr[ADDR_W-1:OFF_W];
  end

  mslru_stats #(.SIZES(SIZES), .CNT_W(CNT_W)) u_stats (
    .clk(clk), .rst_n(rst_q_n), .en(op == OP_ACC), .hit(acc_hit),
    .mask(acc_mask), .hit_cnt(hit_cnt), .miss_cnt(miss_cnt), .acc_cnt(acc_cnt)
  );

  logic unused_offsets;
  assign unused_offsets = ^{acc_addr[OFF_W-1:0], prb_addr[OFF_W-1:0],
                            ins_addr[OFF_W-1:0]};
endmodule

// File: rtl/mslru_tag_store_chk.sv
module mslru_tag_store_chk #(
  parameter int N     = 16,
  parameter int CNT_W = 16,
  localparam int IDX_W = $clog2(N),
  localparam int SIZES = IDX_W
) (
  input logic                    clk,
  input logic                    rst_q_n,
  input logic                    acc_valid,
  input logic                    acc_hit,
  input logic [IDX_W-1:0]        acc_idx,
  input logic [SIZES-1:0]        acc_mask,
  input logic                    ins_valid,
  input logic                    inv_valid,
  input logic [IDX_W-1:0]        inv_idx,
  input logic [N-1:0][IDX_W-1:0] pos,
  input logic [N-1:0]            vld_q,
  input logic [CNT_W-1:0]        acc_cnt
);
  logic [N-1:0] at_front;
  for (genvar i = 0; i < N; i++) begin : g_front
    assign at_front[i] = (pos[i] == '0);
  end

  // R2: no residency on a miss
  p_miss_mask_r2: assert property (@(posedge clk) disable iff (!rst_q_n)
    !acc_hit |-> (acc_mask == '0));

  // R4: a size that holds the entry implies every larger size does too
  p_mask_thermo_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (SIZES'(acc_mask << 1) & ~acc_mask) == '0);

  // R3: a hitting access ends at the front
  p_promote_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    (acc_valid && acc_hit) |=> (pos[$past(acc_idx)] == '0));

  // R3: exactly one entry at the front at all times
  p_single_front_r3: assert property (@(posedge clk) disable iff (!rst_q_n)
    $countones(at_front) == 1);

  // R5 / R8: without access or insert the order holds still
  p_order_still_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!acc_valid && !ins_valid) |=> $stable(pos));

  // R8: invalidated entry reads invalid
  p_invalidate_r8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!acc_valid && !ins_valid && inv_valid) |=> !vld_q[$past(inv_idx)]);

  // R9: access count steps by one
  p_acc_count_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    acc_valid |=> (acc_cnt == CNT_W'($past(acc_cnt) + 1'b1)));
endmodule

bind mslru_tag_store mslru_tag_store_chk #(.N(N), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_q_n(rst_q_n), .acc_valid(acc_valid), .acc_hit(acc_hit),
  .acc_idx(acc_idx), .acc_mask(acc_mask), .ins_valid(ins_valid),
  .inv_valid(inv_valid), .inv_idx(inv_idx), .pos(pos), .vld_q(vld_q),
  .acc_cnt(acc_cnt)
);

// File: tb/mslru_tag_store_test.sv
module mslru_tag_store_test;
  localparam int ADDR_W = 32;
  localparam int OFF_W  = 4;
  localparam int N      = 16;
  localparam int CNT_W  = 16;
  localparam int IDX_W  = 4;
  localparam int SIZES  = 4;
  localparam int TAG_W  = ADDR_W - OFF_W;

  logic clk = 1'b0;
  logic rst_n;
  logic acc_valid, ins_valid, inv_valid;
  logic [ADDR_W-1:0] acc_addr, prb_addr, ins_addr;
  logic [IDX_W-1:0]  inv_idx;
  logic acc_hit, prb_hit;
  logic [IDX_W-1:0] acc_idx, prb_idx, vic_idx;
  logic [SIZES-1:0] acc_mask;
  logic [SIZES:0][CNT_W-1:0] hit_cnt, miss_cnt;
  logic [CNT_W-1:0] acc_cnt;

  always #5 clk = ~clk;

  mslru_tag_store #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .N(N), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
    .acc_hit(acc_hit), .acc_idx(acc_idx), .acc_mask(acc_mask),
    .prb_addr(prb_addr), .prb_hit(prb_hit), .prb_idx(prb_idx),
    .ins_valid(ins_valid), .ins_addr(ins_addr), .vic_idx(vic_idx),
    .inv_valid(inv_valid), .inv_idx(inv_idx), .hit_cnt(hit_cnt),
    .miss_cnt(miss_cnt), .acc_cnt(acc_cnt)
  );

  int n_checks = 0;
  int n_fail   = 0;

  // Reference model built from the requirements.
  logic [TAG_W-1:0] mtag [N];
  bit               mval [N];
  int               mpos [N];
  int e_hit [SIZES+1];
  int e_miss[SIZES+1];
  int e_acc;

  task automatic chk(string req, longint act, longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int m_find(logic [TAG_W-1:0] t);
    for (int i = 0; i < N; i++) if (mval[i] && mtag[i] == t) return i;
    return -1;
  endfunction

  function automatic int m_victim();
    for (int i = 0; i < N; i++) if (!mval[i]) return i;
    for (int i = 0; i < N; i++) if (mpos[i] == N - 1) return i;
    return 0;
  endfunction

  function automatic void m_promote(int e);
    int p = mpos[e];
    for (int j = 0; j < N; j++) if (j != e && mpos[j] < p) mpos[j]++;
    mpos[e] = 0;
  endfunction

  function automatic logic [ADDR_W-1:0] mk(logic [TAG_W-1:0] t, logic [OFF_W-1:0] o);
    return {t, o};
  endfunction

  task automatic idle();
    acc_valid = 0; ins_valid = 0; inv_valid = 0;
  endtask

  task automatic do_access(logic [TAG_W-1:0] t, logic [OFF_W-1:0] o, string req);
    int e = m_find(t);
    logic [SIZES-1:0] em = '0;
    for (int k = 0; k < SIZES; k++) em[k] = (e >= 0) && (mpos[(e<0)?0:e] < (1 << k));
    @(negedge clk);
    acc_valid = 1; acc_addr = mk(t, o);
    #1;
    chk({req, " hit"}, acc_hit, (e >= 0));
    if (e >= 0) chk({req, " idx"}, acc_idx, e);
    chk({req, " mask R4"}, acc_mask, em);
    @(posedge clk); #1;
    idle();
    e_acc++;
    for (int k = 0; k < SIZES; k++) if (em[k]) e_hit[k]++; else e_miss[k]++;
    if (e >= 0) begin e_hit[SIZES]++; m_promote(e); end
    else e_miss[SIZES]++;
  endtask

  task automatic do_insert(logic [TAG_W-1:0] t, string req);
    int v = m_victim();
    @(negedge clk);
    chk({req, " victim R6"}, vic_idx, v);
    ins_valid = 1; ins_addr = mk(t, 4'h9);
    @(posedge clk); #1;
    idle();
    mtag[v] = t; mval[v] = 1; m_promote(v);
  endtask

  task automatic do_probe(logic [TAG_W-1:0] t, logic [OFF_W-1:0] o, string req);
    int e = m_find(t);
    @(negedge clk);
    prb_addr = mk(t, o);
    #1;
    chk({req, " probe hit"}, prb_hit, (e >= 0));
    if (e >= 0) chk({req, " probe idx"}, prb_idx, e);
  endtask

  task automatic chk_counters(string req);
    @(negedge clk);
    chk({req, " acc_cnt"}, acc_cnt, e_acc);
    for (int k = 0; k <= SIZES; k++) begin
      chk({req, " hit_cnt"}, hit_cnt[k], e_hit[k]);
      chk({req, " miss_cnt"}, miss_cnt[k], e_miss[k]);
    end
  endtask

  task automatic t_reset();
    chk_counters("R11 reset");
    chk("R11 reset victim", vic_idx, 0);
    do_probe(28'h0, 4'h0, "R11 reset");
    do_probe(28'h123, 4'h0, "R11 reset");
  endtask

  task automatic t_fill();
    for (int i = 0; i < N; i++) do_insert(TAG_W'(28'h100 + i), "R7 fill");
    @(negedge clk);
    chk("R6 lru victim when full", vic_idx, m_victim());
    for (int i = 0; i < N; i++) do_probe(TAG_W'(28'h100 + i), 4'h3, "R7 fill");
  endtask

  task automatic t_pattern();
    do_access(28'h10F, 4'h0, "R2 front");
    do_access(28'h10E, 4'hF, "R1 offset");
    do_access(28'h10C, 4'h7, "R3 pos3");
    do_access(28'h108, 4'h1, "R3 pos7");
    do_access(28'h100, 4'h2, "R3 tail");
    do_access(28'h10F, 4'h0, "R3 after moves");
  endtask

  task automatic t_probe();
    for (int r = 0; r < 4; r++) do_probe(28'h103, 4'h5, "R5");
    do_probe(28'h999, 4'h0, "R5 miss");
    chk_counters("R5 no count");
    do_access(28'h104, 4'h0, "R5 order kept");
    do_access(28'h103, 4'h0, "R5 order kept");
  endtask

  task automatic t_sweep();
    int s = 7;
    for (int r = 0; r < 40; r++) begin
      s = (s * 5 + 3) % N;
      do_access(TAG_W'(28'h100 + s), OFF_W'(r), "R3 sweep");
    end
  endtask

  task automatic t_miss();
    do_access(28'hABC, 4'h0, "R2 miss");
    do_access(28'h000, 4'h0, "R2 miss");
  endtask

  task automatic t_inval();
    @(negedge clk);
    inv_valid = 1; inv_idx = 4'd5;
    @(posedge clk); #1;
    idle();
    mval[5] = 0;
    do_probe(28'h105, 4'h0, "R8 gone");
    do_access(28'h105, 4'h0, "R8 access miss");
    @(negedge clk);
    chk("R6 free preferred", vic_idx, 5);
    do_insert(28'h555, "R7 refill");
    do_access(28'h555, 4'h0, "R7 new at front");
  endtask

  task automatic t_priority();
    int e = m_find(28'h109);
    @(negedge clk);
    acc_valid = 1; acc_addr = mk(28'h109, 4'h0);
    ins_valid = 1; ins_addr = mk(28'h777, 4'h0);
    inv_valid = 1; inv_idx = 4'd2;
    #1;
    chk("R10 access acts", acc_hit, 1);
    @(posedge clk); #1;
    idle();
    e_acc++;
    for (int k = 0; k < SIZES; k++)
      if (mpos[e] < (1 << k)) e_hit[k]++; else e_miss[k]++;
    e_hit[SIZES]++;
    m_promote(e);
    do_probe(28'h777, 4'h0, "R10 insert ignored");
    do_probe(28'h102, 4'h0, "R10 invalidate ignored");
    // insert versus invalidate: insert acts
    @(negedge clk);
    ins_valid = 1; ins_addr = mk(28'h888, 4'h0);
    inv_valid = 1; inv_idx = 4'd3;
    begin
      int v = m_victim();
      @(posedge clk); #1;
      idle();
      mtag[v] = 28'h888; mval[v] = 1; m_promote(v);
    end
    do_probe(28'h888, 4'h0, "R10 insert acts");
    do_probe(28'h103, 4'h0, "R10 invalidate ignored");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) begin mtag[i] = '0; mval[i] = 0; mpos[i] = i; end
    for (int k = 0; k <= SIZES; k++) begin e_hit[k] = 0; e_miss[k] = 0; end
    e_acc = 0;
    idle();
    acc_addr = '0; prb_addr = '0; ins_addr = '0; inv_idx = '0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    t_fill();
    t_pattern();
    t_probe();
    t_sweep();
    t_miss();
    t_inval();
    t_priority();
    chk_counters("R9 totals");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule